// File: doc/BRIEF.md
# Page write buffer and commit sequencer

This block sits behind the serial-bus protocol engine of a small byte-addressed non-volatile store. When a write transaction opens, it takes the start address. Each data byte that follows goes into a one-page staging buffer at the current offset. Only the offset within the page advances, so a transfer longer than a page wraps and later bytes replace earlier ones at the same offset. A per-offset valid mask records which offsets have actually been received.

Nothing reaches the storage array while bytes are being collected. A Stop that ends a transaction holding at least one data byte starts a commit. The commit scans the buffer and emits one array write for each received offset, provided writing was permitted when the Stop arrived. The same Stop also loads a write-cycle timer, and the busy flag stays high for a fixed number of clock cycles. The window length does not change when the write is blocked, so the protocol engine can withhold acknowledges for the whole window. A repeated Start before Stop throws the collected bytes away. The array is a plain register file with a registered read port, so its contents can be observed.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy` and `mem_we` are both low.
- R2: Data bytes are stored at offsets that start at `wr_addr[3:0]` and increase by one modulo 16 per byte. The page number `wr_addr[7:4]` stays fixed, so offset 15 is followed by offset 0 of the same page.
- R3: When more than 16 bytes arrive before Stop, each offset keeps the last byte received for it.
- R4: No array write occurs before the Stop, and `mem_we` is only ever high while `busy` is high.
- R5: A Stop that ends a transaction with at least one data byte raises `busy` on the next cycle and holds it high for exactly `WCYC_CLKS` cycles.
- R6: Only offsets that received a byte are written, each exactly once. All other locations of the page keep their contents.
- R7: If `wr_permit` is low in the cycle the Stop is sampled, no array write is issued and the array is unchanged. `busy` still lasts the full `WCYC_CLKS` cycles.
- R8: A `bus_start` pulse before Stop discards the collected bytes. No busy window follows and no write is issued, and a later transaction writes only its own bytes.
- R9: A Stop that ends a transaction with no data bytes starts no busy window and issues no write.
- R10: While `busy` is high, `wr_begin`, `byte_vld` and `bus_stop` are ignored. No new busy window and no array write result from them.
- R11: `rd_data` presents the array byte at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_begin | input | 1 | Pulse: a write transaction opens at `wr_addr` |
| wr_addr | input | 8 | Start address of the transaction |
| byte_vld | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Received data byte |
| bus_stop | input | 1 | Pulse: Stop condition seen |
| bus_start | input | 1 | Pulse: repeated Start seen |
| wr_permit | input | 1 | High when the pending write may change the array, sampled with Stop |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The bench goes after the cases where offset arithmetic can go wrong. A start offset near the page end must wrap to offset 0 of the same page; a design that carried into the page number would corrupt the neighbouring page. An overlong burst of twenty bytes must leave the last four values at the first four offsets, which a design that stopped at sixteen would miss. A short burst must leave the rest of its page untouched; without a valid mask, stale buffer contents would be copied back. The busy window is counted for normal, blocked, discarded and empty transactions; a design that tied the window to the write count, or started a cycle on a discarded or empty transaction, would show the wrong length or a spurious window.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_COLLECT = 2'd1,
    SEQ_COMMIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pcw_page_buffer.sv
// One-page staging buffer with a per-offset valid mask.
module pcw_page_buffer #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  vmask;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  vmask <= '0;
    else if (wr_en)  vmask[wr_off] <= 1'b1;
  end

  assign rd_data   = store[rd_off];
  assign rd_valid  = vmask[rd_off];
  assign any_valid = |vmask;
endmodule

// File: rtl/pcw_cycle_timer.sv
// Fixed-length write-cycle timer; busy is high for CYC_CLKS cycles after start.
module pcw_cycle_timer #(
  parameter int CYC_CLKS = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(CYC_CLKS);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/pcw_reg_array.sv
// Simple register-file array, one write port, registered read port.
module pcw_reg_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/page_commit_engine.sv
// Page write sequencer: collect, commit on Stop, timed busy window.
// WCYC_CLKS must exceed the page size plus one so the scan ends inside busy.
module page_commit_engine
  import pcw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WCYC_CLKS = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bus_stop,
  input  logic              bus_start,
  input  logic              wr_permit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] LAST_OFF = '1;

  seq_state_t        state;
  logic [BASE_W-1:0] page_base;
  logic [PAGE_W-1:0] ptr;
  logic [PAGE_W-1:0] scan;
  logic              permit_q;

  logic              accept_begin;
  logic              take_byte;
  logic              launch;
  logic [DATA_W-1:0] buf_rd;
  logic              buf_vld;
  logic              buf_any;

  assign accept_begin = (state == SEQ_IDLE) && wr_begin && !busy;
  assign take_byte    = (state == SEQ_COLLECT) && byte_vld && !bus_start && !bus_stop;
  assign launch       = (state == SEQ_COLLECT) && !bus_start && bus_stop && buf_any;

  pcw_page_buffer #(.DATA_W(DATA_W), .OFF_W(PAGE_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept_begin),
    .wr_en     (take_byte),
    .wr_off    (ptr),
    .wr_data   (byte_data),
    .rd_off    (scan),
    .rd_data   (buf_rd),
    .rd_valid  (buf_vld),
    .any_valid (buf_any)
  );

  pcw_cycle_timer #(.CYC_CLKS(WCYC_CLKS)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (launch),
    .busy  (busy)
  );

  pcw_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      page_base <= '0;
      ptr       <= '0;
      scan      <= '0;
      permit_q  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept_begin) begin
            page_base <= wr_addr[ADDR_W-1:PAGE_W];
            ptr       <= wr_addr[PAGE_W-1:0];
            state     <= SEQ_COLLECT;
          end
        end
        SEQ_COLLECT: begin
          if (bus_start) begin
            state <= SEQ_IDLE;
          end else if (bus_stop) begin
            if (buf_any) begin
              permit_q <= wr_permit;
              scan     <= '0;
              state    <= SEQ_COMMIT;
            end else begin
              state <= SEQ_IDLE;
            end
          end else if (byte_vld) begin
            ptr <= ptr + 1'b1;
          end
        end
        SEQ_COMMIT: begin
          mem_we    <= permit_q && buf_vld;
          mem_waddr <= {page_base, scan};
          mem_wdata <= buf_rd;
          scan      <= scan + 1'b1;
          if (scan == LAST_OFF) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
  parameter int BASE_W    = 4,
  parameter int WCYC_CLKS = 1250000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              busy,
  input logic              mem_we,
  input logic [BASE_W-1:0] page_tag,
  input logic              permit_q
);
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1;
    else           run <= '0;
  end

  p_we_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_stop));

  p_busy_length_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && run != 0) |-> (run == 32'(WCYC_CLKS)));

  p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !permit_q && !$past(mem_we)) |=> !mem_we);

  p_discard_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !bus_stop && !busy) |=> !busy);

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (page_tag == $past(page_tag)));
endmodule

bind page_commit_engine pcw_checker #(
  .BASE_W    (ADDR_W - PAGE_W),
  .WCYC_CLKS (WCYC_CLKS)
) u_pcw_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .busy      (busy),
  .mem_we    (mem_we),
  .page_tag  (mem_waddr[ADDR_W-1:PAGE_W]),
  .permit_q  (permit_q)
);

// File: tb/page_commit_engine_bench.sv
module page_commit_engine_bench;
  localparam int WCYC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_begin = 1'b0;
  logic [7:0] wr_addr = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       bus_stop = 1'b0;
  logic       bus_start = 1'b0;
  logic       wr_permit = 1'b1;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       mem_we;
  logic [7:0] mem_waddr;
  logic [7:0] mem_wdata;
  logic       busy;

  page_commit_engine #(.WCYC_CLKS(WCYC)) u_page_commit_engine (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .bus_stop(bus_stop),
    .bus_start(bus_start), .wr_permit(wr_permit), .rd_addr(rd_addr),
    .rd_data(rd_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  always #2 clk = ~clk;

  int   n_vec = 0;
  int   n_bad = 0;
  int   we_cnt = 0;
  int   busy_cnt = 0;
  logic [7:0] model [256];
  logic       known [256];

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) we_cnt++;
      if (busy)   busy_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_begin(input logic [7:0] a);
    @(negedge clk); wr_begin = 1'b1; wr_addr = a;
    @(negedge clk); wr_begin = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic pulse_stop(input logic permit);
    @(negedge clk); bus_stop = 1'b1; wr_permit = permit;
    @(negedge clk); bus_stop = 1'b0; wr_permit = 1'b1;
  endtask

  task automatic pulse_restart();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Full transaction; model follows R2/R3 offset rules when permitted.
  task automatic do_tx(input logic [7:0] a, input int n, input int seed, input logic permit);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [7:0] loc;
      d   = 8'(seed + i * 13);
      loc = {a[7:4], 4'(a[3:0] + 4'(i))};
      if (permit) begin model[loc] = d; known[loc] = 1'b1; end
    end
    pulse_begin(a);
    for (int i = 0; i < n; i++) pulse_byte(8'(seed + i * 13));
    pulse_stop(permit);
    wait_idle();
  endtask

  task automatic read_cell(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic check_page(input logic [3:0] pg, input string req);
    for (int o = 0; o < 16; o++) begin
      logic [7:0] loc;
      logic [7:0] v;
      loc = {pg, 4'(o)};
      if (known[loc]) begin
        read_cell(loc, v);
        chk(req, v, model[loc]);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 mem_we after reset", mem_we, 0);
  endtask

  task automatic t_fill();
    logic [3:0] pages [5] = '{4'h3, 4'h5, 4'h7, 4'hA, 4'hC};
    for (int p = 0; p < 5; p++) begin
      int w0;
      w0 = we_cnt;
      do_tx({pages[p], 4'h0}, 16, 8'h11 * (p + 1), 1'b1);
      chk("R6 full page write count", we_cnt - w0, 16);
      check_page(pages[p], "R11 R2 full page readback");
    end
  endtask

  task automatic t_wrap();
    int w0;
    w0 = we_cnt;
    do_tx(8'h3D, 5, 8'h80, 1'b1);
    chk("R2 wrap write count", we_cnt - w0, 5);
    check_page(4'h3, "R2 wrap within page");
    check_page(4'h5, "R2 next page untouched");
  endtask

  task automatic t_overflow();
    int w0;
    w0 = we_cnt;
    do_tx(8'h52, 20, 8'h05, 1'b1);
    chk("R3 overflow write count", we_cnt - w0, 16);
    chk("R3 offset 2 holds byte 16", int'(model[8'h52]), int'(8'(8'h05 + 16 * 13)));
    check_page(4'h5, "R3 last byte wins");
  endtask

  task automatic t_partial();
    int w0;
    w0 = we_cnt;
    do_tx(8'h78, 3, 8'hC3, 1'b1);
    chk("R6 partial write count", we_cnt - w0, 3);
    check_page(4'h7, "R6 unreceived offsets kept");
  endtask

  task automatic t_busy_len();
    int b0;
    b0 = busy_cnt;
    do_tx(8'hA4, 2, 8'h99, 1'b1);
    chk("R5 busy window length", busy_cnt - b0, WCYC);
  endtask

  task automatic t_no_early();
    int w0;
    w0 = we_cnt;
    pulse_begin(8'hC1);
    pulse_byte(8'h3C);
    pulse_byte(8'h4D);
    repeat (6) @(negedge clk);
    chk("R4 no write before stop", we_cnt - w0, 0);
    chk("R4 not busy before stop", busy, 0);
    model[8'hC1] = 8'h3C; model[8'hC2] = 8'h4D;
    pulse_stop(1'b1);
    wait_idle();
    chk("R4 writes after stop", we_cnt - w0, 2);
    check_page(4'hC, "R4 committed data");
  endtask

  task automatic t_blocked();
    int w0;
    int b0;
    w0 = we_cnt; b0 = busy_cnt;
    do_tx(8'h30, 16, 8'hEE, 1'b0);
    chk("R7 blocked write count", we_cnt - w0, 0);
    chk("R7 blocked busy length", busy_cnt - b0, WCYC);
    check_page(4'h3, "R7 blocked page unchanged");
  endtask

  task automatic t_restart();
    int w0;
    int b0;
    w0 = we_cnt; b0 = busy_cnt;
    pulse_begin(8'hA0);
    pulse_byte(8'h01);
    pulse_byte(8'h02);
    pulse_restart();
    repeat (4) @(negedge clk);
    chk("R8 no busy after discard", busy_cnt - b0, 0);
    chk("R8 no write after discard", we_cnt - w0, 0);
    do_tx(8'hA9, 1, 8'h5A, 1'b1);
    chk("R8 only new byte written", we_cnt - w0, 1);
    check_page(4'hA, "R8 discarded bytes absent");
  endtask

  task automatic t_empty();
    int w0;
    int b0;
    w0 = we_cnt; b0 = busy_cnt;
    pulse_begin(8'h75);
    pulse_stop(1'b1);
    repeat (4) @(negedge clk);
    chk("R9 empty stop no busy", busy_cnt - b0, 0);
    chk("R9 empty stop no write", we_cnt - w0, 0);
  endtask

  task automatic t_busy_ignore();
    int w0;
    int b0;
    w0 = we_cnt; b0 = busy_cnt;
    pulse_begin(8'h5F);
    pulse_byte(8'h77);
    model[8'h5F] = 8'h77;
    pulse_stop(1'b1);
    pulse_begin(8'hC0);
    pulse_byte(8'hF0);
    pulse_byte(8'hF1);
    pulse_stop(1'b1);
    wait_idle();
    repeat (WCYC + 4) @(negedge clk);
    chk("R10 single busy window", busy_cnt - b0, WCYC);
    chk("R10 single write", we_cnt - w0, 1);
    check_page(4'hC, "R10 ignored bytes not written");
    check_page(4'h5, "R10 accepted byte written");
  endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin known[i] = 1'b0; model[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_wrap();
    t_overflow();
    t_partial();
    t_busy_len();
    t_no_early();
    t_blocked();
    t_restart();
    t_empty();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule